// File: doc/BRIEF.md
# Plug-and-Play Card Configuration Controller

This block is the card-side half of an ISA-style plug-and-play configuration scheme. Host software reaches the card through three 8-bit ports. A write to a fixed address port picks a configuration register. A write to a fixed write-data port stores a byte into that register. A read from a read-data port, whose location software can move, returns the register's contents. Around this register file the block runs the card's life cycle. The card waits for the initiation key, sleeps until software wakes it by card select number, takes part in isolation, and is then configured.

The initiation key detector sits outside the block and arrives as a one-cycle `key_seen` pulse. The serial-identifier comparison is reduced to a stub: register 0x01 returns the byte on `iso_byte`. Resource data comes from an external store through a request/ready handshake. The block buffers one byte of it and shows that byte's availability in a status bit.

The card states and their 2-bit codes on `card_state` are: WAIT_KEY (0), SLEEP (1), ISOLATE (2) and CONFIG (3). The transitions are:
- key-seen: WAIT_KEY to SLEEP.
- wake-isolate: SLEEP to ISOLATE.
- wake-config: SLEEP to CONFIG.
- return-to-key: any state to WAIT_KEY.

Top module: `pnp_cfg_ctrl`

## Requirements
- R1: After reset, `card_state` is WAIT_KEY (0), the CSN, the logical device number and the read-port bits are 0, `res_req` is 0, and `ld_active` equals the default parameter (logical device 0 active, device 1 inactive).
- R2: `key_seen` in WAIT_KEY moves the card to SLEEP at the next clock edge. In every other state it has no effect.
- R3: Every write of a byte to I/O 0x0279 loads it into the register-select latch, in any state. The latch holds its value, so repeated data-port accesses reach the same register without selecting it again.
- R4: In WAIT_KEY, writes to the write-data port (I/O 0x0A79) are ignored. In WAIT_KEY and SLEEP, reads of the read-data port are not claimed (`rd_claim` stays 0).
- R5: A write to register 0x03 in SLEEP whose data equals the CSN moves the card to ISOLATE when the data is 0 and to CONFIG otherwise. A mismatching value leaves the card in SLEEP.
- R6: A write to register 0x00 loads read-port bits 9..2 only in ISOLATE. It is ignored in CONFIG. A read is claimed only when address bits 15..10 are 0, bits 9..2 equal the stored value, and bits 1..0 are 2'b11.
- R7: In ISOLATE, a read of register 0x01 returns `iso_byte`.
- R8: The command bits of register 0x02 take effect one clock after the write and then clear themselves. Bit 2 zeroes the CSN and the read-port bits. Bit 1 returns the card to WAIT_KEY and keeps the CSN. Bit 0 reloads the per-device registers with their defaults and keeps the CSN.
- R9: Register 0x06 (CSN) and register 0x07 (logical device number) can be written and read back in ISOLATE and CONFIG.
- R10: `res_req` is high only in CONFIG, and only while the ready flag is clear. `res_ready` latches `res_byte` and sets bit 0 of register 0x05. A read of register 0x04 returns the byte and clears the flag.
- R11: Register 0x30 bit 0 sets `ld_active` of the selected device; bits 7..1 read back as 0. Register 0x31 bits 1..0 are stored per device and appear on `ld_rchk` at bit positions 2n+1..2n. A selected device number of NLD or above writes nothing and reads 0.
- R12: A read of an unimplemented register returns 0. Register 0x75 returns 4.
- R13: Read data and `rd_claim` are registered. They appear one clock after the cycle in which `bus_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | I/O address of the current bus cycle |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | One-cycle I/O write strobe |
| bus_rd | input | 1 | One-cycle I/O read strobe |
| bus_rdata | output | 8 | Registered read data |
| rd_claim | output | 1 | Registered flag: the last read hit the read-data port |
| key_seen | input | 1 | Pulse from the external initiation-key detector |
| iso_byte | input | 8 | Stub value returned by the serial-isolation register |
| res_req | output | 1 | Request for the next resource-data byte |
| res_ready | input | 1 | Resource byte valid, accepted while `res_req` is high |
| res_byte | input | 8 | Resource-data byte |
| card_state | output | 2 | Card state: 0 WAIT_KEY, 1 SLEEP, 2 ISOLATE, 3 CONFIG |
| ld_active | output | NLD | Activate bit per logical device |
| ld_rchk | output | 2*NLD | Range-check control bits per logical device |

## Verification
The hardest situation to reach is a card in CONFIG that still holds a non-zero CSN from its isolation pass. Only wake-by-CSN enters CONFIG, and the CSN can be written only in ISOLATE or CONFIG. The stimulus therefore wakes the card into ISOLATE with value 0 and writes the CSN there. It then uses control bit 1 to drop back to WAIT_KEY, replays the key, and wakes the card with a mismatching value and then the matching one. That path also shows that the return to WAIT_KEY keeps the CSN. In CONFIG, the resource handshake is driven by hand, so the status bit can be seen before and after the data read.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_KEY = 2'd0,
        ST_SLEEP    = 2'd1,
        ST_ISOLATE  = 2'd2,
        ST_CONFIG   = 2'd3
    } card_st_e;

    localparam logic [15:0] ADDR_PORT  = 16'h0279;
    localparam logic [15:0] WDATA_PORT = 16'h0A79;

    localparam logic [7:0] RG_RDPORT = 8'h00;
    localparam logic [7:0] RG_ISO    = 8'h01;
    localparam logic [7:0] RG_CTRL   = 8'h02;
    localparam logic [7:0] RG_WAKE   = 8'h03;
    localparam logic [7:0] RG_RES    = 8'h04;
    localparam logic [7:0] RG_STAT   = 8'h05;
    localparam logic [7:0] RG_CSN    = 8'h06;
    localparam logic [7:0] RG_LDN    = 8'h07;
    localparam logic [7:0] RG_ACT    = 8'h30;
    localparam logic [7:0] RG_RCHK   = 8'h31;
    localparam logic [7:0] RG_VER    = 8'h75;
    localparam logic [7:0] VER_VAL   = 8'h04;

endpackage

// File: rtl/pnp_port_decode.sv
module pnp_port_decode
    import pnp_cfg_pkg::*;
(
    input  logic [15:0] bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  rdport,
    input  card_st_e    state,
    output logic        addr_wr,
    output logic        data_wr,
    output logic        rdp_rd
);

    logic data_live;
    logic read_live;
    logic rd_match;

    assign data_live = (state != ST_WAIT_KEY);
    assign read_live = (state == ST_ISOLATE) || (state == ST_CONFIG);
    assign rd_match  = (bus_addr[15:10] == 6'd0) &&
                       (bus_addr[9:2] == rdport) &&
                       (bus_addr[1:0] == 2'b11);

    assign addr_wr = bus_wr && (bus_addr == ADDR_PORT);
    assign data_wr = bus_wr && data_live && (bus_addr == WDATA_PORT);
    assign rdp_rd  = bus_rd && read_live && rd_match;

endmodule

// File: rtl/pnp_card_fsm.sv
module pnp_card_fsm
    import pnp_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       key_seen,
    input  logic       wake_wr,
    input  logic [7:0] wake_data,
    input  logic [7:0] csn,
    input  logic       go_wfk,
    output card_st_e   state
);

    card_st_e state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_WAIT_KEY;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (go_wfk) begin
            state_nx = ST_WAIT_KEY;
        end else begin
            unique case (state)
                ST_WAIT_KEY: begin
                    if (key_seen) state_nx = ST_SLEEP;
                end
                ST_SLEEP: begin
                    if (wake_wr && (wake_data == csn)) begin
                        state_nx = (wake_data == 8'd0) ? ST_ISOLATE : ST_CONFIG;
                    end
                end
                ST_ISOLATE: state_nx = ST_ISOLATE;
                ST_CONFIG:  state_nx = ST_CONFIG;
            endcase
        end
    end

endmodule

// File: rtl/pnp_res_fetch.sv
module pnp_res_fetch (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       res_ready,
    input  logic [7:0] res_byte,
    input  logic       take,
    output logic       res_req,
    output logic       flag,
    output logic [7:0] buf_q
);

    assign res_req = enable && !flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            buf_q <= 8'd0;
        end else if (res_req && res_ready) begin
            flag  <= 1'b1;
            buf_q <= res_byte;
        end else if (take) begin
            flag  <= 1'b0;
        end
    end

endmodule

// File: rtl/pnp_ld_regs.sv
module pnp_ld_regs #(
    parameter int unsigned     NLD      = 2,
    parameter logic [NLD-1:0]  ACT_DFLT = NLD'(1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic [7:0]       ldn,
    input  logic             act_wr,
    input  logic             rchk_wr,
    input  logic [1:0]       wdata,
    output logic [NLD-1:0]   ld_active,
    output logic [2*NLD-1:0] ld_rchk,
    output logic             sel_act,
    output logic [1:0]       sel_rchk
);

    for (genvar g = 0; g < NLD; g++) begin : g_ld
        logic       hit;
        logic       act_q;
        logic [1:0] rchk_q;

        assign hit = (ldn == 8'(g));

        always_ff @(posedge clk) begin
            if (rst || reload) begin
                act_q  <= ACT_DFLT[g];
                rchk_q <= 2'b00;
            end else begin
                if (act_wr && hit)  act_q  <= wdata[0];
                if (rchk_wr && hit) rchk_q <= wdata;
            end
        end

        assign ld_active[g]       = act_q;
        assign ld_rchk[2*g +: 2]  = rchk_q;
    end

    always_comb begin
        sel_act  = 1'b0;
        sel_rchk = 2'b00;
        for (int i = 0; i < NLD; i++) begin
            if (ldn == 8'(i)) begin
                sel_act  = ld_active[i];
                sel_rchk = ld_rchk[2*i +: 2];
            end
        end
    end

endmodule

// File: rtl/pnp_cfg_ctrl.sv
module pnp_cfg_ctrl
    import pnp_cfg_pkg::*;
#(
    parameter int unsigned    NLD         = 2,
    parameter logic [NLD-1:0] LD_ACT_DFLT = NLD'(1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             bus_wr,
    input  logic             bus_rd,
    output logic [7:0]       bus_rdata,
    output logic             rd_claim,
    input  logic             key_seen,
    input  logic [7:0]       iso_byte,
    output logic             res_req,
    input  logic             res_ready,
    input  logic [7:0]       res_byte,
    output logic [1:0]       card_state,
    output logic [NLD-1:0]   ld_active,
    output logic [2*NLD-1:0] ld_rchk
);

    card_st_e   state;
    logic       addr_wr;
    logic       data_wr;
    logic       rdp_rd;
    logic [7:0] reg_sel;
    logic [7:0] rdport;
    logic [7:0] csn;
    logic [7:0] ldn;
    logic [2:0] cmd_pend;
    logic       cfg_live;
    logic       wake_wr;
    logic       res_take;
    logic       res_flag;
    logic [7:0] res_buf;
    logic       sel_act;
    logic [1:0] sel_rchk;
    logic [7:0] rd_mux;

    assign cfg_live   = (state == ST_ISOLATE) || (state == ST_CONFIG);
    assign wake_wr    = data_wr && (reg_sel == RG_WAKE);
    assign res_take   = rdp_rd && (reg_sel == RG_RES) && (state == ST_CONFIG);
    assign card_state = state;

    pnp_port_decode u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .rdport   (rdport),
        .state    (state),
        .addr_wr  (addr_wr),
        .data_wr  (data_wr),
        .rdp_rd   (rdp_rd)
    );

    pnp_card_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .key_seen  (key_seen),
        .wake_wr   (wake_wr),
        .wake_data (bus_wdata),
        .csn       (csn),
        .go_wfk    (cmd_pend[1]),
        .state     (state)
    );

    pnp_res_fetch u_res (
        .clk       (clk),
        .rst       (rst),
        .enable    (state == ST_CONFIG),
        .res_ready (res_ready),
        .res_byte  (res_byte),
        .take      (res_take),
        .res_req   (res_req),
        .flag      (res_flag),
        .buf_q     (res_buf)
    );

    pnp_ld_regs #(
        .NLD      (NLD),
        .ACT_DFLT (LD_ACT_DFLT)
    ) u_ld (
        .clk       (clk),
        .rst       (rst),
        .reload    (cmd_pend[0]),
        .ldn       (ldn),
        .act_wr    (data_wr && cfg_live && (reg_sel == RG_ACT)),
        .rchk_wr   (data_wr && cfg_live && (reg_sel == RG_RCHK)),
        .wdata     (bus_wdata[1:0]),
        .ld_active (ld_active),
        .ld_rchk   (ld_rchk),
        .sel_act   (sel_act),
        .sel_rchk  (sel_rchk)
    );

    // Register-select latch: loaded from the address port in every state.
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_sel <= 8'd0;
        end else if (addr_wr) begin
            reg_sel <= bus_wdata;
        end
    end

    // Card-level registers and the self-clearing command bits.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdport   <= 8'd0;
            csn      <= 8'd0;
            ldn      <= 8'd0;
            cmd_pend <= 3'd0;
        end else begin
            cmd_pend <= (data_wr && (reg_sel == RG_CTRL)) ? bus_wdata[2:0] : 3'd0;
            if (data_wr) begin
                case (reg_sel)
                    RG_RDPORT: if (state == ST_ISOLATE) rdport <= bus_wdata;
                    RG_CSN:    if (cfg_live) csn <= bus_wdata;
                    RG_LDN:    if (cfg_live) ldn <= bus_wdata;
                    default: ;
                endcase
            end
            if (cmd_pend[2]) begin
                csn    <= 8'd0;
                rdport <= 8'd0;
            end
        end
    end

    always_comb begin
        case (reg_sel)
            RG_ISO:  rd_mux = (state == ST_ISOLATE) ? iso_byte : 8'd0;
            RG_RES:  rd_mux = res_buf;
            RG_STAT: rd_mux = {7'd0, res_flag};
            RG_CSN:  rd_mux = csn;
            RG_LDN:  rd_mux = ldn;
            RG_ACT:  rd_mux = {7'd0, sel_act};
            RG_RCHK: rd_mux = {6'd0, sel_rchk};
            RG_VER:  rd_mux = VER_VAL;
            default: rd_mux = 8'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= 8'd0;
            rd_claim  <= 1'b0;
        end else begin
            rd_claim <= rdp_rd;
            if (rdp_rd) bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/pnp_cfg_ctrl_chk.sv
module pnp_cfg_ctrl_chk
    import pnp_cfg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       key_seen,
    input logic       bus_rd,
    input card_st_e   state,
    input logic [2:0] cmd_pend,
    input logic       rd_claim,
    input logic       res_req,
    input logic [7:0] csn,
    input logic       wake_wr,
    input logic [7:0] wake_data
);

    a_r2_key_to_sleep: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_KEY && key_seen && !cmd_pend[1]) |=> (state == ST_SLEEP));

    a_r4_idle_no_claim: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (state == ST_WAIT_KEY || state == ST_SLEEP)) |=> !rd_claim);

    a_r5_wake_config: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && wake_wr && wake_data == csn && wake_data != 8'd0 && !cmd_pend[1])
        |=> (state == ST_CONFIG));

    a_r8_cmd_clears_csn: assert property (@(posedge clk) disable iff (rst)
        cmd_pend[2] |=> (csn == 8'd0));

    a_r8_cmd_to_wait_key: assert property (@(posedge clk) disable iff (rst)
        cmd_pend[1] |=> (state == ST_WAIT_KEY));

    a_r10_req_in_config: assert property (@(posedge clk) disable iff (rst)
        res_req |-> (state == ST_CONFIG));

endmodule

bind pnp_cfg_ctrl pnp_cfg_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .key_seen  (key_seen),
    .bus_rd    (bus_rd),
    .state     (state),
    .cmd_pend  (cmd_pend),
    .rd_claim  (rd_claim),
    .res_req   (res_req),
    .csn       (csn),
    .wake_wr   (wake_wr),
    .wake_data (bus_wdata)
);

// File: tb/pnp_cfg_ctrl_tb.sv
module pnp_cfg_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = 16'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        rd_claim;
    logic        key_seen = 1'b0;
    logic [7:0]  iso_byte = 8'hA5;
    logic        res_req;
    logic        res_ready = 1'b0;
    logic [7:0]  res_byte = 8'd0;
    logic [1:0]  card_state;
    logic [1:0]  ld_active;
    logic [3:0]  ld_rchk;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    logic [15:0] rp_addr = 16'h0003;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    pnp_cfg_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .rd_claim   (rd_claim),
        .key_seen   (key_seen),
        .iso_byte   (iso_byte),
        .res_req    (res_req),
        .res_ready  (res_ready),
        .res_byte   (res_byte),
        .card_state (card_state),
        .ld_active  (ld_active),
        .ld_rchk    (ld_rchk)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_port(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wreg(input logic [7:0] r, input logic [7:0] d);
        wr_port(16'h0279, r);
        wr_port(16'h0A79, d);
    endtask

    task automatic rd_port(input logic [15:0] a, output logic [7:0] d, output logic c);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata; c = rd_claim;
    endtask

    task automatic rreg(input logic [7:0] r, output logic [7:0] d, output logic c);
        wr_port(16'h0279, r);
        rd_port(rp_addr, d, c);
    endtask

    task automatic cmd(input logic [7:0] d);
        wreg(8'h02, d);
        @(negedge clk);
    endtask

    task automatic pulse_key();
        @(negedge clk); key_seen = 1'b1;
        @(negedge clk); key_seen = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 state", {6'd0, card_state}, 8'd0);
        check("R1 ld_active", {6'd0, ld_active}, 8'h01);
        check("R1 res_req", {7'd0, res_req}, 8'd0);
    endtask

    task automatic t_wait_key();
        logic [7:0] d; logic c;
        wreg(8'h03, 8'h00);
        check("R4 data port ignored in WAIT_KEY", {6'd0, card_state}, 8'd0);
        rd_port(16'h0003, d, c);
        check("R4 no claim in WAIT_KEY", {7'd0, c}, 8'd0);
        pulse_key();
        check("R2 key moves to SLEEP", {6'd0, card_state}, 8'd1);
        pulse_key();
        check("R2 key ignored in SLEEP", {6'd0, card_state}, 8'd1);
        rd_port(16'h0003, d, c);
        check("R4 no claim in SLEEP", {7'd0, c}, 8'd0);
    endtask

    task automatic t_isolate();
        logic [7:0] d; logic c;
        wreg(8'h03, 8'h00);
        check("R5 wake 0 to ISOLATE", {6'd0, card_state}, 8'd2);
        wreg(8'h00, 8'h9F);
        rp_addr = 16'h027F;
        rreg(8'h01, d, c);
        check("R7 isolation byte", d, 8'hA5);
        check("R6 claim at moved port", {7'd0, c}, 8'd1);
        iso_byte = 8'h3C;
        rd_port(rp_addr, d, c);
        check("R3 select latch kept", d, 8'h3C);
        check("R13 claim registered", {7'd0, c}, 8'd1);
        rd_port(16'h027C, d, c);
        check("R6 low bits must be 11", {7'd0, c}, 8'd0);
        rd_port(16'h0003, d, c);
        check("R6 old port dead", {7'd0, c}, 8'd0);
        wreg(8'h06, 8'h05);
        rreg(8'h06, d, c);
        check("R9 CSN readback", d, 8'h05);
    endtask

    task automatic t_rewake();
        cmd(8'h02);
        check("R8 bit1 to WAIT_KEY", {6'd0, card_state}, 8'd0);
        pulse_key();
        wreg(8'h03, 8'h03);
        check("R5 mismatch stays SLEEP", {6'd0, card_state}, 8'd1);
        wreg(8'h03, 8'h05);
        check("R5 wake CSN to CONFIG (R8 CSN kept)", {6'd0, card_state}, 8'd3);
    endtask

    task automatic t_config_regs();
        logic [7:0] d; logic c;
        wreg(8'h00, 8'h10);
        rreg(8'h06, d, c);
        check("R6 port write ignored in CONFIG", {7'd0, c}, 8'd1);
        wreg(8'h07, 8'h01);
        rreg(8'h07, d, c);
        check("R9 LDN readback", d, 8'h01);
        wreg(8'h30, 8'hFF);
        check("R11 activate device 1", {6'd0, ld_active}, 8'h03);
        rreg(8'h30, d, c);
        check("R11 upper bits read 0", d, 8'h01);
        wreg(8'h31, 8'h03);
        check("R11 range bits out", {4'd0, ld_rchk}, 8'h0C);
        rreg(8'h31, d, c);
        check("R11 range readback", d, 8'h03);
        wreg(8'h07, 8'h05);
        wreg(8'h30, 8'h00);
        check("R11 out-of-range LDN no write", {6'd0, ld_active}, 8'h03);
        rreg(8'h30, d, c);
        check("R11 out-of-range LDN reads 0", d, 8'h00);
        rreg(8'h40, d, c);
        check("R12 unimplemented reads 0", d, 8'h00);
        rreg(8'h75, d, c);
        check("R12 register 0x75", d, 8'h04);
        cmd(8'h01);
        check("R8 bit0 reload active", {6'd0, ld_active}, 8'h01);
        check("R8 bit0 reload range", {4'd0, ld_rchk}, 8'h00);
        rreg(8'h06, d, c);
        check("R8 bit0 keeps CSN", d, 8'h05);
    endtask

    task automatic t_resource();
        logic [7:0] d; logic c;
        check("R10 request in CONFIG", {7'd0, res_req}, 8'd1);
        @(negedge clk); res_byte = 8'h6B; res_ready = 1'b1;
        @(negedge clk); res_ready = 1'b0;
        check("R10 request drops when full", {7'd0, res_req}, 8'd0);
        rreg(8'h05, d, c);
        check("R10 status ready", d, 8'h01);
        rreg(8'h04, d, c);
        check("R10 resource byte", d, 8'h6B);
        rreg(8'h05, d, c);
        check("R10 status cleared", d, 8'h00);
        check("R10 request again", {7'd0, res_req}, 8'd1);
    endtask

    task automatic t_card_reset();
        logic [7:0] d; logic c;
        cmd(8'h04);
        rp_addr = 16'h0003;
        rreg(8'h06, d, c);
        check("R8 bit2 port zeroed", {7'd0, c}, 8'd1);
        check("R8 bit2 CSN zeroed", d, 8'h00);
        rd_port(16'h027F, d, c);
        check("R8 bit2 old port dead", {7'd0, c}, 8'd0);
        cmd(8'h02);
        check("R8 back to WAIT_KEY", {6'd0, card_state}, 8'd0);
        check("R10 no request outside CONFIG", {7'd0, res_req}, 8'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wait_key();
        t_isolate();
        t_rewake();
        t_config_regs();
        t_resource();
        t_card_reset();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule